// File: doc/BRIEF.md
# Grouped Glitch-Free Clock Output Gate

This block takes one reference clock and drives six gated copies of it, split into two groups. Group A covers outputs 0 to 4 and follows enable input `en_a_i`. Group B is output 5 alone and follows `en_b_i`. Each enable is asynchronous to the reference clock. It is retimed through its own register chain clocked on the falling edge. A group therefore starts or stops only while the reference clock is low, and every high pulse that reaches an output is a complete reference high phase.

A disabled group is held at logic low. A change on an enable reaches the outputs a fixed three cycles after the falling edge that samples it, and the delay is the same for enabling and disabling. The two chains are separate, so work on one group leaves the other group's state and timing untouched. An active-low asynchronous reset clears both chains, and all outputs then stay low until the enables have passed through. The board-level pull-up that makes a floating enable read high sits outside this block; inside, each enable is a plain logic input.

Top module: `gated_clk_fanout`

## Requirements
- R1: Outputs 0 to 4 form group A, controlled by `en_a_i`; output 5 forms group B, controlled by `en_b_i`. Each enabled output equals `clk_i`, and all outputs in a group carry the same value.
- R2: A group whose retimed enable is 0 holds all its outputs at 0. The enable pairs (a,b) = 00, 01, 10 and 11 give toggling masks 000000, 100000, 011111 and 111111 (bit 5 on the left).
- R3: An enable value sampled on falling edge k of `clk_i` first appears in the high phase that follows falling edge k+2, and it is absent from the high phases after edges k and k+1. The same latency applies when a group is enabled and when it is disabled.
- R4: Every output is 0 while `clk_i` is low, so gating changes only during the low phase.
- R5: Every high pulse on every output lasts exactly one reference high phase, including the first pulse after enabling and the last pulse before disabling.
- R6: While `rst_ni` is 0, all outputs are 0. After release, all outputs stay 0 through the high phases that follow the first two falling edges.
- R7: A change on one group's enable does not change the other group's outputs at any point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock to distribute |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_a_i | input | 1 | Asynchronous enable for group A (outputs 0..4) |
| en_b_i | input | 1 | Asynchronous enable for group B (output 5) |
| clk_o | output | 6 | Gated clock outputs; bit 5 is group B |

## Verification
The latency properties assume that each enable is stable when the falling edge samples it. A value that changes exactly on that edge has no defined cycle of effect. The stimulus therefore moves an enable either one nanosecond before a falling edge or one nanosecond after it. Those two placements are the asynchronous near-edge cases, and each has a known sampling edge. Reset is released one nanosecond after a falling edge, so the first sampling edge is unambiguous.

// File: rtl/gfo_pkg.sv
`timescale 1ns/1ps
package gfo_pkg;
  localparam int NUM_GRP         = 2;
  localparam int DEF_GRP_A_W     = 5;
  localparam int DEF_GRP_B_W     = 1;
  localparam int DEF_SYNC_STAGES = 3;
endpackage

// File: rtl/en_sync.sv
`timescale 1ns/1ps
// Falling-edge retiming chain; output changes only while clk_i is low.
module en_sync #(
  parameter int STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/clk_gate_bank.sv
`timescale 1ns/1ps
module clk_gate_bank #(
  parameter int WIDTH = 6
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] en_i,
  output logic [WIDTH-1:0] clk_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign clk_o[i] = clk_i & en_i[i];
  end
endmodule

// File: rtl/gated_clk_fanout.sv
`timescale 1ns/1ps
module gated_clk_fanout
  import gfo_pkg::*;
#(
  parameter int GRP_A_W     = DEF_GRP_A_W,
  parameter int GRP_B_W     = DEF_GRP_B_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_a_i,
  input  logic                       en_b_i,
  output logic [GRP_A_W+GRP_B_W-1:0] clk_o
);
  localparam int NUM_OUT = GRP_A_W + GRP_B_W;

  logic [NUM_GRP-1:0] en_raw;
  logic [NUM_GRP-1:0] en_live;
  logic [NUM_OUT-1:0] lane_en;

  assign en_raw = {en_b_i, en_a_i};

  // one independent chain per group (R7)
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    en_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (en_raw[g]),
      .q_o   (en_live[g])
    );
  end

  assign lane_en = {{GRP_B_W{en_live[1]}}, {GRP_A_W{en_live[0]}}};

  clk_gate_bank #(.WIDTH(NUM_OUT)) u_bank (
    .clk_i(clk_i),
    .en_i (lane_en),
    .clk_o(clk_o)
  );
endmodule

// File: rtl/gated_clk_fanout_chk.sv
`timescale 1ns/1ps
// Checker; the latency properties are written for the default three-stage chain.
module gated_clk_fanout_chk #(
  parameter int GRP_A_W = 5,
  parameter int GRP_B_W = 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       en_a_i,
  input logic                       en_b_i,
  input logic [GRP_A_W+GRP_B_W-1:0] clk_o
);
  localparam int NUM_OUT = GRP_A_W + GRP_B_W;

  logic [1:0] fall_cnt;
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              fall_cnt <= '0;
    else if (fall_cnt != 2'd3) fall_cnt <= fall_cnt + 2'd1;
  end

  a_r4_low_phase_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_o == '0);

  a_r1_group_uniform: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ($countones(clk_o[GRP_A_W-1:0]) == 0) || ($countones(clk_o[GRP_A_W-1:0]) == GRP_A_W));

  a_r3_grp_a_latency: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (fall_cnt == 2'd3) |-> (clk_o[GRP_A_W-1:0] == {GRP_A_W{$past(en_a_i, 3)}}));

  a_r7_grp_b_latency: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (fall_cnt == 2'd3) |-> (clk_o[NUM_OUT-1:GRP_A_W] == {GRP_B_W{$past(en_b_i, 3)}}));

  a_r6_post_reset_quiet: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (fall_cnt != 2'd3) |-> (clk_o == '0));

  always @(negedge clk_i) begin
    if (!rst_ni) a_r6_reset_low: assert (clk_o == '0);
  end
endmodule

bind gated_clk_fanout gated_clk_fanout_chk #(
  .GRP_A_W(GRP_A_W),
  .GRP_B_W(GRP_B_W)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_a_i(en_a_i),
  .en_b_i(en_b_i),
  .clk_o (clk_o)
);

// File: tb/sim_gated_clk_fanout.sv
`timescale 1ns/1ps
module sim_gated_clk_fanout;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int NVEC       = 9;
  // {en_a, en_b, expected toggling mask[5:0]}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b00_000000, 8'b01_100000, 8'b11_111111, 8'b10_011111, 8'b00_000000,
    8'b10_011111, 8'b11_111111, 8'b01_100000, 8'b11_111111
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_a = 1'b1;
  logic       en_b = 1'b1;
  logic [5:0] clk_out;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #(HALF) clk = ~clk;

  gated_clk_fanout u0 (
    .clk_i (clk),
    .rst_ni(rst_n),
    .en_a_i(en_a),
    .en_b_i(en_b),
    .clk_o (clk_out)
  );

  task automatic check(input bit ok, input string req, input logic [5:0] act, input logic [5:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // sample in the high phase after the next falling edge
  task automatic sample_high(output logic [5:0] v);
    @(negedge clk);
    #(CLK_PERIOD * 3 / 4);
    v = clk_out;
  endtask

  task automatic sample_low(output logic [5:0] v);
    @(negedge clk);
    #(CLK_PERIOD / 4);
    v = clk_out;
  endtask

  // early: 1 ns before a falling edge; otherwise 1 ns after one
  task automatic set_en(input logic a, input logic b, input bit early);
    if (early) begin
      @(posedge clk);
      #(HALF - 1);
    end else begin
      @(negedge clk);
      #1;
    end
    en_a = a;
    en_b = b;
  endtask

  // R5: every high pulse on every lane is one full high phase
  for (genvar gi = 0; gi < 6; gi++) begin : g_pw
    realtime t_rise = 0.0;
    always @(posedge clk_out[gi]) t_rise = $realtime;
    always @(negedge clk_out[gi]) begin
      if (rst_n && !done)
        check(($realtime - t_rise) == HALF, "R5 pulse width", 6'(int'($realtime - t_rise)), 6'(HALF));
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] v;
    logic [5:0] prev;
    // R6: reset holds all outputs low with both enables high
    repeat (2) begin
      sample_high(v);
      check(v == 6'b0, "R6 in reset", v, 6'b0);
    end
    @(negedge clk);
    #1 rst_n = 1'b1;
    sample_high(v); check(v == 6'b0, "R6 after release edge 0", v, 6'b0);
    sample_high(v); check(v == 6'b0, "R6 after release edge 1", v, 6'b0);
    sample_high(v); check(v == 6'b111111, "R6 R1 after release edge 2", v, 6'b111111);
    prev = 6'b111111;

    for (int i = 0; i < NVEC; i++) begin
      set_en(VEC[i][7], VEC[i][6], (i % 2) == 1);
      sample_high(v); check(v == prev, "R3 R7 old value edge k", v, prev);
      sample_high(v); check(v == prev, "R3 R7 old value edge k+1", v, prev);
      sample_high(v); check(v == VEC[i][5:0], "R1 R2 new mask edge k+2", v, VEC[i][5:0]);
      sample_low(v);  check(v == 6'b0, "R4 low phase", v, 6'b0);
      prev = VEC[i][5:0];
    end

    // R7: toggling group B leaves group A running on every sample
    set_en(1'b1, 1'b0, 1'b0);
    repeat (4) begin
      sample_high(v);
      check(v[4:0] == 5'b11111, "R7 group A undisturbed", v, {v[5], 5'b11111});
    end
    set_en(1'b1, 1'b1, 1'b1);
    repeat (4) begin
      sample_high(v);
      check(v[4:0] == 5'b11111, "R7 group A undisturbed", v, {v[5], 5'b11111});
    end

    // R6: mid-run reset clears outputs at once
    @(negedge clk);
    #1 rst_n = 1'b0;
    sample_high(v); check(v == 6'b0, "R6 mid-run reset", v, 6'b0);
    @(negedge clk);
    #1 rst_n = 1'b1;
    sample_high(v); check(v == 6'b0, "R6 re-release edge 0", v, 6'b0);
    sample_high(v); check(v == 6'b0, "R6 re-release edge 1", v, 6'b0);
    sample_high(v); check(v == 6'b111111, "R6 re-release edge 2", v, 6'b111111);
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule